// File: doc/BRIEF.md
# Status Snapshot Latch

This block freezes a coherent copy of three live status vectors into three readable status registers, A, B and C, so that software reading them one after another sees values that all belong to the same clock cycle. A copy is taken on one of two triggers. The first is a bus write to a dedicated snapshot address, and the data on the bus is ignored. The second is the active edge of the accumulation interrupt line, which only counts when the interrupt-enable bit of the setup register is set. Software is expected to use one trigger or the other: the polled scheme with interrupts disabled, or the interrupt-driven scheme with them enabled.

The block also owns the measurement interrupt output. A measurement event sets it. A bus read clears it, and a setup bit selects which read does so: either a read of the measurement status address or a read of status register B. The setup register is written over the same bus. Only its interrupt-enable bit (bit 5) and its clear-source bit (bit 10) are acted on here. The bits that set the interrupt period and the front-end mode are decoded elsewhere, and bits 15 to 11 are unused.

Top module: `stat_snap_latch`

## Requirements
- R1: After reset, stat_a, stat_b, stat_c and meas_int are 0. The setup bits also come out of reset at 0, so accumulation edges do not capture and the register-B read is the clear source.
- R2: A write strobe (wr_en high for one or more cycles) at address A_SNAP causes a capture at the first clock edge where wr_en is sampled low again. At that edge all three status registers load live_a, live_b and live_c, whatever value wr_data carries.
- R3: At any edge with no trigger, the status registers keep their value, even while the live inputs change or while a snapshot write strobe is still high.
- R4: With setup bit 5 set to 1, the clock edge that first samples accum_int high after it was low captures all three live vectors.
- R5: With setup bit 5 at 0, a rising accum_int does not change the status registers.
- R6: Writes to any address other than A_SNAP never cause a capture.
- R7: A meas_evt sampled high at a clock edge makes meas_int 1 from that edge on.
- R8: With setup bit 10 set to 1, a read (rd_en high) at A_MEAS_STAT clears meas_int at that edge, and a read at A_STAT_B does not.
- R9: With setup bit 10 at 0, a read at A_STAT_B clears meas_int, and a read at A_MEAS_STAT does not.
- R10: When meas_evt and a clearing read are sampled at the same edge, meas_int ends up 1.
- R11: While accum_int stays high, it causes no further captures. Only its low-to-high transition triggers.
- R12: When the snapshot-write trailing edge and an accumulation edge fall on the same clock edge, exactly one capture of the live vectors sampled at that edge is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_en | input | 1 | Bus write strobe, held for the length of the write |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data (used only for the setup register) |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| rd_addr | input | AW | Read address |
| accum_int | input | 1 | Accumulation interrupt line (active edge set by ACC_RISE) |
| meas_evt | input | 1 | Measurement event pulse that raises meas_int |
| live_a | input | SW | Live status vector for register A |
| live_b | input | SW | Live status vector for register B |
| live_c | input | SW | Live status vector for register C |
| stat_a | output | SW | Latched status register A |
| stat_b | output | SW | Latched status register B |
| stat_c | output | SW | Latched status register C |
| meas_int | output | 1 | Measurement interrupt output |

## Verification
The hardest case to reach is the collision in R12. The last cycle of a snapshot write strobe has to end exactly one cycle before accum_int rises, while interrupts are enabled, and the live vectors have to change on every cycle so that a double or late capture would show up. A directed sequence lines up these two edges on purpose. A seeded random phase then toggles wr_en, the address, accum_int and the setup bits freely, so that collisions and R10-style set/clear overlaps also occur in combinations nobody planned. Each cycle is compared against a cycle-accurate bench model.

// File: rtl/ssl_pkg.sv
`timescale 1ns/1ps
package ssl_pkg;
   localparam int SETUP_W      = 16;
   localparam int BIT_IRQ_EN   = 5;
   localparam int BIT_MEAS_SRC = 10;
   localparam int N_STAT       = 3;

   typedef enum logic [1:0] {
      TRG_NONE  = 2'b00,
      TRG_WRITE = 2'b01,
      TRG_IRQ   = 2'b10,
      TRG_BOTH  = 2'b11
   } trig_e;
endpackage

// File: rtl/ssl_edge.sv
`timescale 1ns/1ps
// Synchronous edge detector; ACT_HIGH picks the rising or falling variant.
module ssl_edge #(
   parameter bit ACT_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   generate
      if (ACT_HIGH) begin : g_rise
         assign pulse = sig & ~prev_q;
      end else begin : g_fall
         assign pulse = ~sig & prev_q;
      end
   endgenerate
endmodule

// File: rtl/ssl_snap_reg.sv
`timescale 1ns/1ps
// One status holding register, loaded only on a capture strobe.
module ssl_snap_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= d;
   end
endmodule

// File: rtl/ssl_meas_irq.sv
`timescale 1ns/1ps
// Measurement interrupt flag: set by event, cleared by the selected read.
module ssl_meas_irq #(
   parameter int          AW      = 4,
   parameter logic [AW-1:0] A_SEL1 = '0,
   parameter logic [AW-1:0] A_SEL0 = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_evt,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic          src_sel,
   output logic          irq
);
   logic [AW-1:0] clr_addr;
   logic          clr_hit;

   assign clr_addr = src_sel ? A_SEL1 : A_SEL0;
   assign clr_hit  = rd_en && (rd_addr == clr_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq <= 1'b0;
      else if (set_evt) irq <= 1'b1;   // a new event beats a clear
      else if (clr_hit) irq <= 1'b0;
   end
endmodule

// File: rtl/stat_snap_latch.sv
`timescale 1ns/1ps
module stat_snap_latch
   import ssl_pkg::*;
#(
   parameter int            SW          = 16,
   parameter int            AW          = 4,
   parameter logic [AW-1:0] A_SNAP      = 4'h2,
   parameter logic [AW-1:0] A_SETUP     = 4'h3,
   parameter logic [AW-1:0] A_MEAS_STAT = 4'h5,
   parameter logic [AW-1:0] A_STAT_B    = 4'h9,
   parameter bit            ACC_RISE    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [15:0]   wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic          accum_int,
   input  logic          meas_evt,
   input  logic [SW-1:0] live_a,
   input  logic [SW-1:0] live_b,
   input  logic [SW-1:0] live_c,
   output logic [SW-1:0] stat_a,
   output logic [SW-1:0] stat_b,
   output logic [SW-1:0] stat_c,
   output logic          meas_int
);
   // elaboration-time parameter checks
   generate
      if (SW < 1 || SW > 32) begin : g_bad_sw
         $error("stat_snap_latch: SW must lie in 1..32");
      end
      if (AW < 2) begin : g_bad_aw
         $error("stat_snap_latch: AW too small for four addresses");
      end
      if (A_SNAP == A_SETUP || A_MEAS_STAT == A_STAT_B) begin : g_bad_map
         $error("stat_snap_latch: address map collision");
      end
   endgenerate

   // setup register: only the bits acted on here are held
   logic irq_en_q, meas_src_q, setup_wr;
   assign setup_wr = wr_en && (wr_addr == A_SETUP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q   <= 1'b0;
         meas_src_q <= 1'b0;
      end else if (setup_wr) begin
         irq_en_q   <= wr_data[BIT_IRQ_EN];
         meas_src_q <= wr_data[BIT_MEAS_SRC];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{wr_data[15:BIT_MEAS_SRC+1],
                           wr_data[BIT_MEAS_SRC-1:BIT_IRQ_EN+1],
                           wr_data[BIT_IRQ_EN-1:0]};

   // trigger sources
   logic snap_hit, wr_trig, acc_edge, irq_trig, cap;
   trig_e trig;

   assign snap_hit = wr_en && (wr_addr == A_SNAP);

   ssl_edge #(.ACT_HIGH(1'b0)) u_wr_edge (
      .clk(clk), .rst_n(rst_n), .sig(snap_hit), .pulse(wr_trig));

   ssl_edge #(.ACT_HIGH(ACC_RISE)) u_acc_edge (
      .clk(clk), .rst_n(rst_n), .sig(accum_int), .pulse(acc_edge));

   assign irq_trig = acc_edge & irq_en_q;
   assign trig     = trig_e'({irq_trig, wr_trig});
   assign cap      = (trig != TRG_NONE);   // both at once still one load

   // the three holding registers share one strobe
   logic [SW-1:0] live_arr [N_STAT];
   logic [SW-1:0] stat_arr [N_STAT];
   assign live_arr[0] = live_a;
   assign live_arr[1] = live_b;
   assign live_arr[2] = live_c;

   generate
      for (genvar i = 0; i < N_STAT; i++) begin : g_reg
         ssl_snap_reg #(.W(SW)) u_reg (
            .clk(clk), .rst_n(rst_n), .cap(cap),
            .d(live_arr[i]), .q(stat_arr[i]));
      end
   endgenerate

   assign stat_a = stat_arr[0];
   assign stat_b = stat_arr[1];
   assign stat_c = stat_arr[2];

   ssl_meas_irq #(.AW(AW), .A_SEL1(A_MEAS_STAT), .A_SEL0(A_STAT_B)) u_meas (
      .clk(clk), .rst_n(rst_n), .set_evt(meas_evt), .rd_en(rd_en),
      .rd_addr(rd_addr), .src_sel(meas_src_q), .irq(meas_int));
endmodule

// File: rtl/ssl_chk.sv
`timescale 1ns/1ps
module ssl_chk #(
   parameter int            SW          = 16,
   parameter int            AW          = 4,
   parameter logic [AW-1:0] A_SNAP      = 4'h2,
   parameter logic [AW-1:0] A_SETUP     = 4'h3,
   parameter logic [AW-1:0] A_MEAS_STAT = 4'h5,
   parameter logic [AW-1:0] A_STAT_B    = 4'h9,
   parameter bit            ACC_RISE    = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [15:0]   wr_data,
   input logic          rd_en,
   input logic [AW-1:0] rd_addr,
   input logic          accum_int,
   input logic          meas_evt,
   input logic [SW-1:0] live_a,
   input logic [SW-1:0] live_b,
   input logic [SW-1:0] live_c,
   input logic [SW-1:0] stat_a,
   input logic [SW-1:0] stat_b,
   input logic [SW-1:0] stat_c,
   input logic          meas_int
);
   // observation state rebuilt from the ports
   logic hit_q, acc_q, ie_q, src_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0; acc_q <= 1'b0; ie_q <= 1'b0; src_q <= 1'b0;
      end else begin
         hit_q <= wr_en && (wr_addr == A_SNAP);
         acc_q <= accum_int;
         if (wr_en && (wr_addr == A_SETUP)) begin
            ie_q  <= wr_data[5];
            src_q <= wr_data[10];
         end
      end
   end

   logic w_tr, a_edge;
   assign w_tr   = hit_q && !(wr_en && (wr_addr == A_SNAP));
   assign a_edge = ACC_RISE ? (accum_int && !acc_q) : (!accum_int && acc_q);

   p_wr_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      w_tr |=> (stat_a == $past(live_a)) && (stat_b == $past(live_b))
               && (stat_c == $past(live_c)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_tr && !(a_edge && ie_q)) |=> $stable(stat_a) && $stable(stat_b)
                                       && $stable(stat_c));

   p_irq_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_edge && ie_q) |=> (stat_a == $past(live_a)) && (stat_b == $past(live_b))
                           && (stat_c == $past(live_c)));

   p_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (a_edge && !ie_q && !w_tr) |=> $stable(stat_a));

   p_meas_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      meas_evt |=> meas_int);

   p_meas_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q && rd_en && rd_addr == A_MEAS_STAT && !meas_evt) |=> !meas_int);

   p_meas_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_q && rd_en && rd_addr == A_STAT_B && !meas_evt) |=> !meas_int);
endmodule

bind stat_snap_latch ssl_chk #(
   .SW(SW), .AW(AW), .A_SNAP(A_SNAP), .A_SETUP(A_SETUP),
   .A_MEAS_STAT(A_MEAS_STAT), .A_STAT_B(A_STAT_B), .ACC_RISE(ACC_RISE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
   .accum_int(accum_int), .meas_evt(meas_evt), .live_a(live_a),
   .live_b(live_b), .live_c(live_c), .stat_a(stat_a), .stat_b(stat_b),
   .stat_c(stat_c), .meas_int(meas_int));

// File: tb/stat_snap_latch_bench.sv
`timescale 1ns/1ps
module stat_snap_latch_bench;
   localparam int SW = 16;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_SNAP  = 4'h2;
   localparam logic [AW-1:0] A_SETUP = 4'h3;
   localparam logic [AW-1:0] A_MSTA  = 4'h5;
   localparam logic [AW-1:0] A_STB   = 4'h9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, accum_int = 1'b0, meas_evt = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [15:0]   wr_data = '0;
   logic [SW-1:0] live_a = '0, live_b = '0, live_c = '0;
   logic [SW-1:0] stat_a, stat_b, stat_c;
   logic          meas_int;

   always #5 clk = ~clk;

   stat_snap_latch u_stat_snap_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .accum_int(accum_int), .meas_evt(meas_evt), .live_a(live_a),
      .live_b(live_b), .live_c(live_c), .stat_a(stat_a), .stat_b(stat_b),
      .stat_c(stat_c), .meas_int(meas_int));

   int checks = 0, errors = 0;
   string tag = "R1";

   // bench model, derived from the requirements
   logic [SW-1:0] m_a = '0, m_b = '0, m_c = '0;
   logic m_hq = 0, m_aq = 0, m_ie = 0, m_src = 0, m_meas = 0;

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] rnd_w();
      return SW'($urandom);
   endfunction

   task automatic rnd_live();
      live_a = rnd_w(); live_b = rnd_w(); live_c = rnd_w();
   endtask

   // next state predicted from inputs as they stand before the edge
   task automatic model_step();
      logic hit, trig, clr;
      hit  = wr_en && wr_addr == A_SNAP;
      trig = (m_hq && !hit) || (m_ie && accum_int && !m_aq);
      clr  = rd_en && rd_addr == (m_src ? A_MSTA : A_STB);
      if (trig) begin m_a = live_a; m_b = live_b; m_c = live_c; end
      m_hq = hit; m_aq = accum_int;
      if (wr_en && wr_addr == A_SETUP) begin m_ie = wr_data[5]; m_src = wr_data[10]; end
      if (meas_evt) m_meas = 1'b1; else if (clr) m_meas = 1'b0;
   endtask

   task automatic cyc();
      model_step();
      @(negedge clk);
      chk(stat_a == m_a, tag, 32'(stat_a), 32'(m_a));
      chk(stat_b == m_b, tag, 32'(stat_b), 32'(m_b));
      chk(stat_c == m_c, tag, 32'(stat_c), 32'(m_c));
      chk(meas_int == m_meas, tag, 32'(meas_int), 32'(m_meas));
   endtask

   task automatic wr_pulse(input logic [AW-1:0] a, input logic [15:0] d, input int len);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      for (int k = 0; k < len; k++) begin rnd_live(); cyc(); end
      wr_en = 1'b0;
   endtask

   task automatic rd_once(input logic [AW-1:0] a);
      rd_en = 1'b1; rd_addr = a; cyc(); rd_en = 1'b0;
   endtask

   initial begin
      #1_500_000;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [SW-1:0] ea;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(stat_a == '0 && stat_b == '0 && stat_c == '0, "R1", 32'(stat_a), 0);
      chk(meas_int == 1'b0, "R1", 32'(meas_int), 0);
      tag = "R1"; accum_int = 1'b1; rnd_live(); cyc(); accum_int = 1'b0; cyc();

      // R2 + R3: snapshot write, live moving during the strobe
      tag = "R3"; wr_pulse(A_SNAP, 16'hFFFF, 4);
      tag = "R2"; ea = live_a; cyc();
      chk(stat_a == ea, "R2", 32'(stat_a), 32'(ea));
      tag = "R3"; rnd_live(); cyc(); cyc();

      // R6: other addresses, including setup with enable clear
      tag = "R6"; wr_pulse(A_MSTA, 16'h0000, 2); rnd_live(); cyc();
      wr_pulse(4'hF, 16'hFFFF, 1); rnd_live(); cyc();
      wr_pulse(A_SETUP, 16'h0000, 1); rnd_live(); cyc();

      // R5: accumulation edge with interrupts disabled
      tag = "R5"; ea = stat_a; accum_int = 1'b1; rnd_live(); cyc();
      chk(stat_a == ea, "R5", 32'(stat_a), 32'(ea));
      accum_int = 1'b0; cyc();

      // R4 + R11: enable, then an edge held high
      tag = "R4"; wr_pulse(A_SETUP, 16'h0020, 1); cyc();
      accum_int = 1'b1; rnd_live(); ea = live_a; cyc();
      chk(stat_a == ea, "R4", 32'(stat_a), 32'(ea));
      tag = "R11";
      for (int k = 0; k < 4; k++) begin rnd_live(); cyc(); end
      chk(stat_a == ea, "R11", 32'(stat_a), 32'(ea));
      accum_int = 1'b0; rnd_live(); cyc();

      // R12: write trailing edge on the same edge as accum rise
      tag = "R12"; wr_pulse(A_SNAP, 16'h1234, 2);
      accum_int = 1'b1; rnd_live(); ea = live_b; cyc();
      chk(stat_b == ea, "R12", 32'(stat_b), 32'(ea));
      rnd_live(); cyc(); accum_int = 1'b0; cyc();

      // R7, R9, R10 with clear source = register B read
      tag = "R7"; meas_evt = 1'b1; cyc(); meas_evt = 1'b0;
      chk(meas_int == 1'b1, "R7", 32'(meas_int), 1);
      tag = "R9"; rd_once(A_MSTA);
      chk(meas_int == 1'b1, "R9", 32'(meas_int), 1);
      rd_once(A_STB);
      chk(meas_int == 1'b0, "R9", 32'(meas_int), 0);
      tag = "R10"; meas_evt = 1'b1; rd_en = 1'b1; rd_addr = A_STB; cyc();
      meas_evt = 1'b0; rd_en = 1'b0;
      chk(meas_int == 1'b1, "R10", 32'(meas_int), 1);

      // R8: clear source = measurement status read
      tag = "R8"; wr_pulse(A_SETUP, 16'h0420, 1); cyc();
      rd_once(A_STB);
      chk(meas_int == 1'b1, "R8", 32'(meas_int), 1);
      rd_once(A_MSTA);
      chk(meas_int == 1'b0, "R8", 32'(meas_int), 0);

      // seeded random mix checked against the model
      tag = "R12";
      for (int n = 0; n < 4000; n++) begin
         int p;
         p = $urandom_range(0, 9);
         wr_en = (p < 4);
         case ($urandom_range(0, 4))
            0: wr_addr = A_SETUP;
            1: wr_addr = A_MSTA;
            2: wr_addr = 4'hF;
            default: wr_addr = A_SNAP;
         endcase
         wr_data   = 16'($urandom);
         accum_int = ($urandom_range(0, 3) == 0) ? ~accum_int : accum_int;
         meas_evt  = ($urandom_range(0, 7) == 0);
         rd_en     = ($urandom_range(0, 3) == 0);
         rd_addr   = $urandom_range(0, 1) ? A_MSTA : A_STB;
         rnd_live();
         cyc();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule